// File: doc/BRIEF.md
# Trap Value Capture Register

This block holds the trap value registers of a small core at two privilege levels, machine and supervisor. When a synchronous exception commits, the block writes one word into one of the two registers. That word is the faulting address, the faulting program counter, the raw bits of the offending instruction, or zero. Which one is chosen depends on the exception cause.

For an illegal-instruction trap, the block decodes the instruction length from the low bits of the fetched pattern. It keeps only the bits that belong to that instruction and clears everything above them, so no stale data survives from an earlier trap. Encodings wider than 32 bits are not supported, and they record zero.

A flag that marks the trap as delegated steers the write to the supervisor register. Software can also write either register through a simple CSR port. When a trap write and a software write reach the same register in the same cycle, the trap write wins. Both register values are visible on output ports at all times.

Top module: `tval_capture`

## Requirements
- R1: After a synchronous active-high reset, both the machine and supervisor value outputs are zero.
- R2: A committed trap with cause 0, 1, 4, 5, 6 or 7 (misaligned or access-fault on fetch, load or store) records `fault_addr`.
- R3: A committed trap with cause 3 (breakpoint) records `fault_pc`.
- R4: For cause 2 (illegal instruction) with compressed support on and `fetch_bits[1:0]` not equal to 2'b11, the low 16 bits record `fetch_bits[15:0]` and every higher bit is zero.
- R5: For cause 2 with compressed support off, all 32 fetched bits are recorded, whatever the low two bits are, and bits 32 and up are zero.
- R6: For cause 2 where `fetch_bits[1:0]` is 2'b11 and `fetch_bits[4:2]` is not 3'b111, all 32 fetched bits are recorded, bits 32 and up are zero, and the compressed setting has no effect.
- R7: For cause 2 where `fetch_bits[4:0]` is 5'b11111 (an unsupported encoding longer than 32 bits), the value recorded is zero.
- R8: A committed trap with any cause from 8 to 15 records zero.
- R9: A trap with `trap_to_super` high writes the supervisor register and leaves the machine register unchanged. With the flag low, the machine register is written and the supervisor register is unchanged.
- R10: A CSR write with `csr_sel` 0 loads the machine register and a write with `csr_sel` 1 loads the supervisor register. The other register keeps its value.
- R11: When a trap and a CSR write target the same register in the same cycle, the trap value is the one stored.
- R12: While `trap_commit` is low, the trap inputs have no effect on either register.
- R13: Every update becomes visible on the outputs one clock after the input edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trap_commit | input | 1 | Exception commit strobe |
| trap_cause | input | 4 | Exception cause code |
| trap_to_super | input | 1 | Exception is delegated to supervisor level |
| fault_addr | input | XLEN | Faulting data or fetch address |
| fault_pc | input | XLEN | Program counter of the trapping instruction |
| fetch_bits | input | 32 | Raw fetched instruction bits |
| compressed_en | input | 1 | 16-bit instruction formats are enabled |
| csr_we | input | 1 | Software write strobe |
| csr_sel | input | 1 | Write target: 0 machine, 1 supervisor |
| csr_wdata | input | XLEN | Software write data |
| mtval_q | output | XLEN | Machine trap value register |
| stval_q | output | XLEN | Supervisor trap value register |

## Verification
Before each illegal-instruction trap, the bench fills the target register with all ones. After the trap, any upper bits that were not cleared stand out. The same fetched pattern, with low bits other than 2'b11, is sent once with compressed support on and once with it off. This separates the 16-bit case from the 32-bit case. Further patterns cover a 32-bit encoding under both settings and an all-ones-low-five pattern that must record zero. The bench also walks through every address cause, breakpoint and an environment-call cause, uses distinct address and PC values so that a swapped source shows, and tries delegated traps, trap-versus-software collisions and strobe-low stimulus.

// File: rtl/tval_pkg.sv
package tval_pkg;

    localparam int CAUSE_W   = 4;
    localparam int INSN_W    = 32;
    localparam int HALF_W    = 16;
    localparam int NUM_SLOTS = 2;
    localparam int SLOT_M    = 0;
    localparam int SLOT_S    = 1;

    // Where the recorded word comes from
    typedef enum logic [1:0] {
        SRC_ZERO = 2'd0,
        SRC_ADDR = 2'd1,
        SRC_PC   = 2'd2,
        SRC_INSN = 2'd3
    } src_e;

    // Decoded instruction length class
    typedef enum logic [1:0] {
        LEN_HALF = 2'd0,
        LEN_WORD = 2'd1,
        LEN_LONG = 2'd2
    } len_e;

    typedef struct packed {
        logic  commit;
        logic  to_super;
        src_e  src;
    } trap_ctl_t;

    function automatic src_e cause_to_src(input logic [CAUSE_W-1:0] cause);
        src_e s;
        case (cause)
            4'd0, 4'd1, 4'd4, 4'd5, 4'd6, 4'd7: s = SRC_ADDR;
            4'd2:                                s = SRC_INSN;
            4'd3:                                s = SRC_PC;
            default:                             s = SRC_ZERO;
        endcase
        return s;
    endfunction

    function automatic len_e decode_len(input logic [4:0] low, input logic c_on);
        len_e l;
        if (low[1:0] != 2'b11)
            l = c_on ? LEN_HALF : LEN_WORD;
        else if (low[4:2] != 3'b111)
            l = LEN_WORD;
        else
            l = LEN_LONG;
        return l;
    endfunction

endpackage

// File: rtl/tval_len_decode.sv
module tval_len_decode
    import tval_pkg::*;
(
    input  logic [4:0] low_bits,
    input  logic       c_on,
    output len_e       len
);
    always_comb len = decode_len(low_bits, c_on);
endmodule

// File: rtl/tval_value_sel.sv
module tval_value_sel
    import tval_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  src_e              src,
    input  len_e              len,
    input  logic [XLEN-1:0]   addr,
    input  logic [XLEN-1:0]   pc,
    input  logic [INSN_W-1:0] insn,
    output logic [XLEN-1:0]   value
);
    localparam int KEEP_W = (INSN_W < XLEN) ? INSN_W : XLEN;

    logic [XLEN-1:0] insn_half;
    logic [XLEN-1:0] insn_word;

    always_comb begin
        insn_half              = '0;
        insn_half[HALF_W-1:0]  = insn[HALF_W-1:0];
        insn_word              = '0;
        insn_word[KEEP_W-1:0]  = insn[KEEP_W-1:0];
    end

    always_comb begin
        value = '0;
        case (src)
            SRC_ADDR: value = addr;
            SRC_PC:   value = pc;
            SRC_INSN: begin
                case (len)
                    LEN_HALF: value = insn_half;
                    LEN_WORD: value = insn_word;
                    default:  value = '0;
                endcase
            end
            default:  value = '0;
        endcase
    end
endmodule

// File: rtl/tval_slot.sv
module tval_slot #(
    parameter int XLEN = 64
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            trap_we,
    input  logic [XLEN-1:0] trap_val,
    input  logic            sw_we,
    input  logic [XLEN-1:0] sw_val,
    output logic [XLEN-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (trap_we)
            q <= trap_val;
        else if (sw_we)
            q <= sw_val;
    end
endmodule

// File: rtl/tval_capture.sv
module tval_capture
    import tval_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                trap_commit,
    input  logic [CAUSE_W-1:0]  trap_cause,
    input  logic                trap_to_super,
    input  logic [XLEN-1:0]     fault_addr,
    input  logic [XLEN-1:0]     fault_pc,
    input  logic [INSN_W-1:0]   fetch_bits,
    input  logic                compressed_en,
    input  logic                csr_we,
    input  logic                csr_sel,
    input  logic [XLEN-1:0]     csr_wdata,
    output logic [XLEN-1:0]     mtval_q,
    output logic [XLEN-1:0]     stval_q
);
    trap_ctl_t       ctl;
    len_e            len;
    logic [XLEN-1:0] new_val;
    logic [XLEN-1:0] slot_q [NUM_SLOTS];

    always_comb begin
        ctl.commit   = trap_commit;
        ctl.to_super = trap_to_super;
        ctl.src      = cause_to_src(trap_cause);
    end

    tval_len_decode u_len (
        .low_bits (fetch_bits[4:0]),
        .c_on     (compressed_en),
        .len      (len)
    );

    tval_value_sel #(.XLEN(XLEN)) u_sel (
        .src   (ctl.src),
        .len   (len),
        .addr  (fault_addr),
        .pc    (fault_pc),
        .insn  (fetch_bits),
        .value (new_val)
    );

    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
        logic hit_trap;
        logic hit_sw;
        always_comb begin
            hit_trap = ctl.commit & (ctl.to_super == (i == SLOT_S));
            hit_sw   = csr_we & (csr_sel == (i == SLOT_S));
        end
        tval_slot #(.XLEN(XLEN)) u_slot (
            .clk      (clk),
            .rst      (rst),
            .trap_we  (hit_trap),
            .trap_val (new_val),
            .sw_we    (hit_sw),
            .sw_val   (csr_wdata),
            .q        (slot_q[i])
        );
    end

    assign mtval_q = slot_q[SLOT_M];
    assign stval_q = slot_q[SLOT_S];
endmodule

// File: rtl/tval_capture_chk.sv
module tval_capture_chk
    import tval_pkg::*;
#(
    parameter int XLEN = 64
) (
    input logic                clk,
    input logic                rst,
    input logic                trap_commit,
    input logic [CAUSE_W-1:0]  trap_cause,
    input logic                trap_to_super,
    input logic [XLEN-1:0]     fault_addr,
    input logic [XLEN-1:0]     fault_pc,
    input logic [INSN_W-1:0]   fetch_bits,
    input logic                compressed_en,
    input logic                csr_we,
    input logic                csr_sel,
    input logic [XLEN-1:0]     csr_wdata,
    input logic [XLEN-1:0]     mtval_q,
    input logic [XLEN-1:0]     stval_q
);
    typedef logic [XLEN-1:0] word_t;

    logic rst_seen;
    always_ff @(posedge clk) rst_seen <= rst;

    // R1
    always_ff @(posedge clk) begin
        if (rst_seen === 1'b1)
            reset_zero_chk: assert (mtval_q == '0 && stval_q == '0);
    end

    logic m_trap;
    assign m_trap = trap_commit && !trap_to_super;

    // R2
    addr_cause_chk: assert property (@(posedge clk) disable iff (rst)
        m_trap && (trap_cause == 4'd1 || trap_cause == 4'd5 || trap_cause == 4'd7)
        |=> mtval_q == $past(fault_addr));

    // R3
    bkpt_pc_chk: assert property (@(posedge clk) disable iff (rst)
        m_trap && trap_cause == 4'd3 |=> mtval_q == $past(fault_pc));

    // R4
    half_insn_chk: assert property (@(posedge clk) disable iff (rst)
        m_trap && trap_cause == 4'd2 && compressed_en && fetch_bits[1:0] != 2'b11
        |=> mtval_q == word_t'($past(fetch_bits[15:0])));

    // R5
    no_c_word_chk: assert property (@(posedge clk) disable iff (rst)
        m_trap && trap_cause == 4'd2 && !compressed_en && fetch_bits[4:0] != 5'b11111
        |=> mtval_q == word_t'($past(fetch_bits)));

    // R7
    long_zero_chk: assert property (@(posedge clk) disable iff (rst)
        m_trap && trap_cause == 4'd2 && fetch_bits[4:0] == 5'b11111 |=> mtval_q == '0);

    // R9
    deleg_keep_m_chk: assert property (@(posedge clk) disable iff (rst)
        trap_commit && trap_to_super && !(csr_we && !csr_sel) |=> $stable(mtval_q));

    // R10
    sw_write_chk: assert property (@(posedge clk) disable iff (rst)
        csr_we && csr_sel && !trap_commit |=> stval_q == $past(csr_wdata));

    // R11
    trap_wins_chk: assert property (@(posedge clk) disable iff (rst)
        m_trap && csr_we && !csr_sel && trap_cause == 4'd9 |=> mtval_q == '0);

    // R12
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !trap_commit && !csr_we |=> $stable(mtval_q) && $stable(stval_q));
endmodule

bind tval_capture tval_capture_chk #(.XLEN(XLEN)) u_chk (.*);

// File: tb/test_tval_capture.sv
module test_tval_capture;
    localparam int XLEN = 64;
    typedef logic [XLEN-1:0] word_t;

    logic        clk = 1'b0;
    logic        rst;
    logic        trap_commit, trap_to_super, compressed_en, csr_we, csr_sel;
    logic [3:0]  trap_cause;
    word_t       fault_addr, fault_pc, csr_wdata, mtval_q, stval_q;
    logic [31:0] fetch_bits;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    tval_capture #(.XLEN(XLEN)) i_tval_capture (.*);

    localparam word_t ADDR = 64'h1234_5678_9ABC_DEF0;
    localparam word_t PC   = 64'h0000_0040_8000_0100;
    localparam word_t ONES = '1;

    task automatic check(input string req, input word_t act, input word_t exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        trap_commit = 0; trap_to_super = 0; trap_cause = 0;
        csr_we = 0; csr_sel = 0; csr_wdata = '0;
    endtask

    // drive at negedge, registers update at posedge, sample at next negedge
    task automatic cycle();
        @(posedge clk);
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic sw_write(input logic sel, input word_t v);
        csr_we = 1; csr_sel = sel; csr_wdata = v;
        cycle();
    endtask

    task automatic trap(input logic [3:0] c, input logic sup, input logic [31:0] f, input logic cen);
        trap_commit = 1; trap_cause = c; trap_to_super = sup;
        fault_addr = ADDR; fault_pc = PC; fetch_bits = f; compressed_en = cen;
        cycle();
    endtask

    task automatic t_reset();
        check("R1 machine after reset", mtval_q, '0);
        check("R1 supervisor after reset", stval_q, '0);
    endtask

    task automatic t_addr_causes();
        int cl[6] = '{0, 1, 4, 5, 6, 7};
        foreach (cl[k]) begin
            sw_write(0, '0);
            trap(cl[k][3:0], 0, 32'hFFFF_FFFF, 1);
            check($sformatf("R2 cause %0d address", cl[k]), mtval_q, ADDR);
        end
    endtask

    task automatic t_breakpoint();
        trap(4'd3, 0, 32'h0, 1);
        check("R3 breakpoint pc", mtval_q, PC);
    endtask

    task automatic t_illegal();
        sw_write(0, ONES);
        trap(4'd2, 0, 32'hABCD_5552, 1);
        check("R4 half with c on", mtval_q, 64'h5552);
        sw_write(0, ONES);
        trap(4'd2, 0, 32'hABCD_5552, 0);
        check("R5 full word with c off", mtval_q, 64'hABCD_5552);
        sw_write(0, ONES);
        trap(4'd2, 0, 32'h0010_0073, 1);
        check("R6 word encoding c on", mtval_q, 64'h0010_0073);
        sw_write(0, ONES);
        trap(4'd2, 0, 32'h0010_0073, 0);
        check("R6 word encoding c off", mtval_q, 64'h0010_0073);
        sw_write(0, ONES);
        trap(4'd2, 0, 32'h1234_567F, 1);
        check("R7 long encoding zero", mtval_q, '0);
        sw_write(0, ONES);
        trap(4'd2, 0, 32'h1234_565F, 0);
        check("R7 long encoding zero c off", mtval_q, '0);
    endtask

    task automatic t_other_cause();
        sw_write(0, ONES);
        trap(4'd8, 0, 32'h0, 1);
        check("R8 cause 8 zero", mtval_q, '0);
        sw_write(0, ONES);
        trap(4'd15, 0, 32'h0, 1);
        check("R8 cause 15 zero", mtval_q, '0);
    endtask

    task automatic t_delegate();
        sw_write(0, 64'hAAAA);
        sw_write(1, 64'h5555);
        trap(4'd5, 1, 32'h0, 1);
        check("R9 supervisor written", stval_q, ADDR);
        check("R9 machine kept", mtval_q, 64'hAAAA);
        trap(4'd3, 0, 32'h0, 1);
        check("R9 machine written", mtval_q, PC);
        check("R9 supervisor kept", stval_q, ADDR);
    endtask

    task automatic t_sw();
        sw_write(0, 64'hDEAD_BEEF_0000_0001);
        check("R10 machine write", mtval_q, 64'hDEAD_BEEF_0000_0001);
        sw_write(1, 64'hCAFE_0000_0000_0002);
        check("R10 supervisor write", stval_q, 64'hCAFE_0000_0000_0002);
        check("R10 machine untouched", mtval_q, 64'hDEAD_BEEF_0000_0001);
    endtask

    task automatic t_collide();
        csr_we = 1; csr_sel = 0; csr_wdata = 64'h7777;
        trap(4'd9, 0, 32'h0, 1);
        check("R11 trap beats sw machine", mtval_q, '0);
        csr_we = 1; csr_sel = 1; csr_wdata = 64'h8888;
        trap(4'd3, 1, 32'h0, 1);
        check("R11 trap beats sw supervisor", stval_q, PC);
        csr_we = 1; csr_sel = 1; csr_wdata = 64'h9999;
        trap(4'd1, 0, 32'h0, 1);
        check("R11 no collision machine", mtval_q, ADDR);
        check("R11 no collision supervisor", stval_q, 64'h9999);
    endtask

    task automatic t_idle();
        sw_write(0, 64'h1111);
        sw_write(1, 64'h2222);
        trap_cause = 4'd1; fault_addr = ONES; fetch_bits = '1;
        cycle();
        check("R12 machine held", mtval_q, 64'h1111);
        check("R12 supervisor held", stval_q, 64'h2222);
    endtask

    task automatic t_latency();
        trap_commit = 1; trap_cause = 4'd0; trap_to_super = 0; fault_addr = 64'h4242;
        @(posedge clk);
        #1;
        check("R13 visible right after edge", mtval_q, 64'h4242);
        @(negedge clk);
        idle_inputs();
    endtask

    initial begin
        idle_inputs();
        fault_addr = '0; fault_pc = '0; fetch_bits = '0; compressed_en = 1;
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        t_reset();
        t_addr_causes();
        t_breakpoint();
        t_illegal();
        t_other_cause();
        t_delegate();
        t_sw();
        t_collide();
        t_idle();
        t_latency();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule